// File: doc/BRIEF.md
# Four-Channel Edge-Aligned PWM Timer

The block is a 16-bit up-counter that drives four PWM outputs, all sharing one time base. A write-only register port sets up the timer. Through it, software programs a clock divider, the period, one threshold per channel, the channel modes and the output gating. The counter runs from zero up to the active period value, then returns to zero, so every output pulse begins at the start of a cycle.

Threshold and period values can be double-buffered. When buffering is on, a write only changes a pending copy. The pending copy moves into the active copy at the next counter wrap, or at once when software issues a load event. A new value therefore never cuts short or stretches the cycle that is already running. Without buffering, a write takes effect on the next clock.

Register writes are taken on the rising clock edge while `wr_en` is high. Registers are selected by `wr_addr`.

Top module: `pwm4_timer`

## Requirements
- R1: After reset, every output is low and the counter stays stopped until it is enabled.
- R2: With divider value 0 and active period P, the counter steps through 0..P, one value per clock, and then returns to 0. A channel in PWM mode 1 with active threshold C is high while the count is below C. Over any whole period it is high for C clocks.
- R3: Address 1 holds the divider value D. The counter advances once every D+1 clocks.
- R4: An active threshold of 0 keeps the output low all the time. A threshold greater than the period keeps it high all the time.
- R5: In each channel's mode byte, bit 3 turns on threshold buffering. With it set, a write to that channel's threshold register (address 8+k) is held back until the next wrap. The running cycle keeps the old threshold.
- R6: With bit 3 of the mode byte clear, a threshold write takes effect on the next clock, in the middle of the cycle.
- R7: Address 0 is the control register. Its bit 1 turns on period buffering. With bit 1 set, a write to the period register (address 2) takes effect only at the next wrap. With bit 1 clear, it takes effect on the next clock.
- R8: Writing 1 to bit 0 of address 6 does three things at once: it clears the counter and the divider, and it copies every pending threshold and the pending period into the active copies. Nothing stays latched, so counting carries on from zero.
- R9: A channel output can be high only when all of these hold: control bit 0 (count enable) is set, control bit 2 (output drive) is set, and the channel's enable bit is set, at bit 4k of address 5. The channel's mode field must also equal 6 (PWM mode 1). The mode field is bits [2:0] of its mode byte: channels 0 and 1 use bytes [7:0] and [15:8] of address 3, and channels 2 and 3 use the same bytes of address 4. In every other case the output is low, and when count enable is clear the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| pwm | output | 4 | PWM outputs, one per channel |

## Verification
Any fault in the counter or the divider changes the period length or the duty count at the next wrap. Such a fault is therefore visible within one period, and the bench measures high-clock counts over whole periods, so the result does not depend on phase. A pending/active mix-up has a different signature: the output either changes in the middle of a cycle or fails to change after the wrap. The bench samples one clock after a write that lands below the current count, and again after the following wrap. A gating fault shows up on the very next clock as a high output where the output should be low.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
    localparam int unsigned ADDR_W = 4;

    // register addresses
    localparam logic [ADDR_W-1:0] ADR_CTRL   = 4'd0;
    localparam logic [ADDR_W-1:0] ADR_DIV    = 4'd1;
    localparam logic [ADDR_W-1:0] ADR_PER    = 4'd2;
    localparam logic [ADDR_W-1:0] ADR_MODE01 = 4'd3;
    localparam logic [ADDR_W-1:0] ADR_OUTEN  = 4'd5;
    localparam logic [ADDR_W-1:0] ADR_EVENT  = 4'd6;
    localparam logic [ADDR_W-1:0] ADR_THR0   = 4'd8;

    // control register bits
    localparam int unsigned CTL_RUN_BIT   = 0;
    localparam int unsigned CTL_PERBUF_BIT = 1;
    localparam int unsigned CTL_DRIVE_BIT = 2;
    localparam int unsigned EV_LOAD_BIT   = 0;

    localparam logic [2:0] MODE_PWM1 = 3'd6;
endpackage

// File: rtl/pwm4_prescaler.sv
module pwm4_prescaler #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         clr,
    input  logic [W-1:0] limit,
    output logic         tick
);
    logic [W-1:0] div_d, div_q;

    assign tick = run && (div_q >= limit);

    always_comb begin
        div_d = div_q;
        if (clr) begin
            div_d = '0;
        end else if (run) begin
            div_d = tick ? '0 : div_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/pwm4_channel.sv
module pwm4_channel import pwm4_pkg::*; #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         mode_wr,
    input  logic [3:0]   mode_in,
    input  logic         thr_wr,
    input  logic [W-1:0] thr_in,
    input  logic         load,
    input  logic [W-1:0] count,
    input  logic         gate,
    output logic         pwm,
    output logic [W-1:0] thr_act,
    output logic         thr_buf
);
    typedef struct packed {
        logic [W-1:0] pend;
        logic [W-1:0] act;
        logic [2:0]   mode;
        logic         buf_on;
    } ch_state_t;

    ch_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (mode_wr) begin
            s_d.mode   = mode_in[2:0];
            s_d.buf_on = mode_in[3];
        end
        if (thr_wr) begin
            s_d.pend = thr_in;
            if (!s_q.buf_on) s_d.act = thr_in;
        end
        if (load) s_d.act = s_d.pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign pwm     = gate && (s_q.mode == MODE_PWM1) && (count < s_q.act);
    assign thr_act = s_q.act;
    assign thr_buf = s_q.buf_on;
endmodule

// File: rtl/pwm4_timer.sv
module pwm4_timer import pwm4_pkg::*; #(
    parameter int unsigned W          = 16,
    parameter int unsigned NCH        = 4,
    parameter int unsigned DEF_PERIOD = 1023,
    parameter int unsigned DEF_DIV    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    output logic [NCH-1:0]    pwm
);
    localparam int unsigned OE_STRIDE = 4;

    typedef struct packed {
        logic           run;
        logic           per_buf;
        logic           drive;
        logic [W-1:0]   div;
        logic [W-1:0]   per_pend;
        logic [W-1:0]   per_act;
        logic [W-1:0]   cnt;
        logic [NCH-1:0] oe;
    } tmr_state_t;

    tmr_state_t s_d, s_q;
    logic tick, force_ld, wrap, load;
    logic [NCH-1:0][W-1:0] thr_act;
    logic [NCH-1:0]        thr_buf;

    // signals brought out for the bound checker
    logic [W-1:0] cnt_now, per_now;
    logic         run_now, drive_now;
    assign cnt_now   = s_q.cnt;
    assign per_now   = s_q.per_act;
    assign run_now   = s_q.run;
    assign drive_now = s_q.drive;

    assign force_ld = wr_en && (wr_addr == ADR_EVENT) && wr_data[EV_LOAD_BIT];
    assign wrap     = tick && (s_q.cnt == s_q.per_act);
    assign load     = force_ld || wrap;

    pwm4_prescaler #(.W(W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (s_q.run),
        .clr   (force_ld),
        .limit (s_q.div),
        .tick  (tick)
    );

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            case (wr_addr)
                ADR_CTRL: begin
                    s_d.run     = wr_data[CTL_RUN_BIT];
                    s_d.per_buf = wr_data[CTL_PERBUF_BIT];
                    s_d.drive   = wr_data[CTL_DRIVE_BIT];
                end
                ADR_DIV: s_d.div = wr_data;
                ADR_PER: begin
                    s_d.per_pend = wr_data;
                    if (!s_q.per_buf) s_d.per_act = wr_data;
                end
                ADR_OUTEN: begin
                    for (int k = 0; k < NCH; k++) s_d.oe[k] = wr_data[OE_STRIDE*k];
                end
                default: ;
            endcase
        end
        if (load) s_d.per_act = s_d.per_pend;
        if (force_ld || wrap) s_d.cnt = '0;
        else if (tick)        s_d.cnt = s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q          <= '0;
            s_q.div      <= W'(DEF_DIV);
            s_q.per_pend <= W'(DEF_PERIOD);
            s_q.per_act  <= W'(DEF_PERIOD);
        end else begin
            s_q <= s_d;
        end
    end

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        localparam logic [ADDR_W-1:0] MODE_ADR = ADDR_W'(int'(ADR_MODE01) + k / 2);
        localparam logic [ADDR_W-1:0] THR_ADR  = ADDR_W'(int'(ADR_THR0) + k);
        localparam int unsigned       BYTE_LO  = 8 * (k % 2);

        pwm4_channel #(.W(W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .mode_wr (wr_en && (wr_addr == MODE_ADR)),
            .mode_in (wr_data[BYTE_LO +: 4]),
            .thr_wr  (wr_en && (wr_addr == THR_ADR)),
            .thr_in  (wr_data),
            .load    (load),
            .count   (s_q.cnt),
            .gate    (s_q.run && s_q.drive && s_q.oe[k]),
            .pwm     (pwm[k]),
            .thr_act (thr_act[k]),
            .thr_buf (thr_buf[k])
        );
    end
endmodule

// File: rtl/pwm4_timer_chk.sv
module pwm4_timer_chk #(
    parameter int unsigned W   = 16,
    parameter int unsigned NCH = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  run,
    input logic                  drive,
    input logic                  tick,
    input logic                  force_ld,
    input logic                  load,
    input logic [W-1:0]          cnt,
    input logic [W-1:0]          per_act,
    input logic [NCH-1:0]        pwm,
    input logic [NCH-1:0]        thr_buf,
    input logic [NCH-1:0][W-1:0] thr_act
);
    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == per_act && !force_ld) |=> cnt == '0);

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt != per_act && !force_ld) |=> cnt == $past(cnt) + 1'b1);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !force_ld) |=> $stable(cnt));

    p_load_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        force_ld |=> cnt == '0);

    p_gate_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(run && drive) |-> pwm == '0);

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        p_zero_thr_r4: assert property (@(posedge clk) disable iff (!rst_n)
            thr_act[k] == '0 |-> !pwm[k]);

        p_buf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (thr_buf[k] && !load) |=> $stable(thr_act[k]));
    end
endmodule

bind pwm4_timer pwm4_timer_chk #(.W(W), .NCH(NCH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_now),
    .drive    (drive_now),
    .tick     (tick),
    .force_ld (force_ld),
    .load     (load),
    .cnt      (cnt_now),
    .per_act  (per_now),
    .pwm      (pwm),
    .thr_buf  (thr_buf),
    .thr_act  (thr_act)
);

// File: tb/pwm4_timer_bench.sv
module pwm4_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [3:0]  pwm;
    int total = 0;
    int bad = 0;

    always #5 clk = ~clk;

    pwm4_timer u_pwm4_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pwm     (pwm)
    );

    // called at a falling edge; write is taken at the next rising edge
    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic highs(input int ch, input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm[ch]) c++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset;
        check("R1 outputs after reset", int'(pwm), 0);
        idle(5);
        check("R1 outputs stay low while stopped", int'(pwm), 0);
    endtask

    task automatic t_basic;
        int c;
        wr(4'd1, 16'd0);
        wr(4'd2, 16'd9);
        wr(4'd3, 16'h0606);
        wr(4'd4, 16'h0606);
        wr(4'd5, 16'h1111);
        wr(4'd8, 16'd3);
        wr(4'd9, 16'd7);
        wr(4'd10, 16'd0);
        wr(4'd11, 16'd12);
        wr(4'd0, 16'h0005);
        idle(20);
        highs(0, 20, c); check("R2 ch0 duty 3 of 10", c, 6);
        highs(1, 20, c); check("R2 ch1 duty 7 of 10", c, 14);
        highs(2, 20, c); check("R4 threshold zero", c, 0);
        highs(3, 20, c); check("R4 threshold above period", c, 20);
    endtask

    task automatic t_divider;
        int c;
        wr(4'd1, 16'd1);
        idle(20);
        highs(0, 40, c); check("R3 divide by two", c, 12);
        wr(4'd1, 16'd0);
        idle(20);
    endtask

    task automatic t_gating;
        int c;
        wr(4'd0, 16'h0001);
        highs(3, 20, c); check("R9 drive bit clear", c, 0);
        wr(4'd0, 16'h0004);
        highs(3, 20, c); check("R9 count enable clear", c, 0);
        wr(4'd0, 16'h0005);
        wr(4'd5, 16'h0111);
        highs(3, 20, c); check("R9 channel enable clear", c, 0);
        wr(4'd5, 16'h1111);
        wr(4'd4, 16'h0006);
        highs(3, 20, c); check("R9 mode not pwm1", c, 0);
        wr(4'd4, 16'h0606);
        highs(3, 20, c); check("R9 all gates open", c, 20);
    endtask

    task automatic t_thr_buffer;
        int c;
        wr(4'd3, 16'h060E);
        wr(4'd8, 16'd8);
        wr(4'd6, 16'h0001);
        highs(0, 10, c); check("R8 load copies pending threshold", c, 8);
        idle(4);
        wr(4'd8, 16'd2);
        check("R5 old threshold kept mid-cycle", int'(pwm[0]), 1);
        idle(5);
        highs(0, 10, c); check("R5 new threshold after wrap", c, 2);
    endtask

    task automatic t_thr_direct;
        wr(4'd6, 16'h0001);
        idle(4);
        wr(4'd9, 16'd2);
        check("R6 unbuffered threshold immediate", int'(pwm[1]), 0);
    endtask

    task automatic t_period;
        int c;
        wr(4'd0, 16'h0007);
        wr(4'd6, 16'h0001);
        idle(4);
        wr(4'd2, 16'd4);
        idle(5);
        highs(0, 10, c); check("R7 buffered period at wrap", c, 4);
        wr(4'd0, 16'h0005);
        wr(4'd6, 16'h0001);
        idle(2);
        wr(4'd2, 16'd9);
        highs(0, 7, c); check("R7 unbuffered period immediate", c, 0);
    endtask

    initial begin
        #100000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_divider();
        t_gating();
        t_thr_buffer();
        t_thr_direct();
        t_period();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule